// File: doc/BRIEF.md
# Microprogram Next-Address Controller

This block is the control logic that sits around an external microprogram sequencer in a small microprogrammed machine. A 32-bit pipeline register holds the microinstruction currently executing, which is the word the external 16-word microprogram store returns at the sequencer's output address. The register splits that word into fields. Some fields go straight to the sequencer: the branch address, carry-in and branch-register load. Others go to the ALU slice: source, function, destination, A and B addresses and carry-in.

Next-address selection is table driven. A 4-bit control opcode taken from the microinstruction forms the upper part of a lookup address. One condition bit, picked from a registered status word, forms the least significant bit. The table entry gives the sequencer its source select, stack enable, push/pop direction and OR-mask bits. A second per-opcode table picks which stored flag feeds the condition bit and whether the status register captures the live ALU flags. This gives continue, jump, call, return, conditional jumps on any flag polarity, conditional call and return, and a two-way dispatch, all without hardwired next-address decode. The block also decodes a 2-bit shift field into the four shift-in bits used at the ends of the ALU slice's register file and Q register.

Top module: `mp_next_ctl`

## Requirements
- R1: On every rising clock edge the pipeline register loads `fetch_word`. Synchronous reset loads the all-zero word, which is a plain continue with zero-fill shifting and all fields zero.
- R2: Field positions in the microinstruction: [31:28] control opcode, [27:24] branch address to `seq_d`, [23] `seq_cin`, [22] `seq_rld`, [21:20] shift code, [19:17] `alu_src`, [16:14] `alu_fn`, [13:11] `alu_dst`, [10:7] `a_addr`, [6:3] `b_addr`, [2] `alu_cin`, [1:0] unused.
- R3: Source select encoding: 0 = microprogram counter, 1 = branch register, 2 = stack top, 3 = direct input. Opcode 0 (continue) and opcode 14 (continue and load status) select source 0 with the stack idle. Opcode 1 (jump) selects source 3.
- R4: Opcodes 4 to 7 jump (source 3) when the stored flag chosen by opcode bits [1:0] is 1, and continue otherwise. Opcodes 8 to 11 jump when that flag is 0. The flag index is 0 carry, 1 zero, 2 most significant bit, 3 overflow.
- R5: Opcode 2 (call) gives source 3 with stack enable and push. Opcode 3 (return) gives source 2 with stack enable and pop (`seq_push` = 0). Opcode 12 calls only when the stored zero flag is 1. Opcode 13 returns only when the stored zero flag is 1. Otherwise both continue with the stack idle.
- R6: Opcode 15 selects source 3 with `seq_or` = {3'b000, stored zero flag}. Every other opcode drives `seq_or` to zero.
- R7: The status register captures `alu_flags` at a clock edge only while opcode 14 is in the pipeline register. Reset clears it.
- R8: Conditions come from the stored status, never from the live `alu_flags` of the current cycle.
- R9: Shift code 0 drives all four shift-in bits to 0. Code 1 drives them to 1. Code 2 rotates: `ram_hi_in` = `ram_lo_out`, `ram_lo_in` = `ram_hi_out`, `q_hi_in` = `q_lo_out`, `q_lo_in` = `q_hi_out`. Code 3 is arithmetic: `ram_hi_in` = `ram_hi_out`, `q_hi_in` = `ram_lo_out`, and both low-end inputs are 0.
- R10: Driven by a sequencer model and a microprogram that counts the ones in a register word, the block steers the program through call, conditional branches, continue, return and an unconditional jump loop. The count then equals the number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 32 | Store word at the sequencer's output address |
| alu_flags | input | 4 | Live ALU flags: [0] carry, [1] zero, [2] MSB, [3] overflow |
| ram_lo_out | input | 1 | Bit leaving the low end of the register-file shifter |
| ram_hi_out | input | 1 | Bit at the high end of the register-file shifter |
| q_lo_out | input | 1 | Bit leaving the low end of the Q shifter |
| q_hi_out | input | 1 | Bit at the high end of the Q shifter |
| seq_src | output | 2 | Sequencer source select |
| seq_fe | output | 1 | Sequencer stack enable |
| seq_push | output | 1 | 1 push, 0 pop when enabled |
| seq_or | output | 4 | Sequencer OR mask |
| seq_d | output | 4 | Branch address to the sequencer direct input |
| seq_cin | output | 1 | Sequencer incrementer carry-in |
| seq_rld | output | 1 | Sequencer branch-register load |
| alu_src | output | 3 | ALU source field |
| alu_fn | output | 3 | ALU function field |
| alu_dst | output | 3 | ALU destination field |
| a_addr | output | 4 | Register-file A address |
| b_addr | output | 4 | Register-file B address |
| alu_cin | output | 1 | ALU carry-in |
| ram_lo_in | output | 1 | Shift-in bit at the register-file low end |
| ram_hi_in | output | 1 | Shift-in bit at the register-file high end |
| q_lo_in | output | 1 | Shift-in bit at the Q low end |
| q_hi_in | output | 1 | Shift-in bit at the Q high end |

## Verification
The status register and the pipeline register are the only state. A wrong status bit does not show until a later conditional opcode reads it. It then appears as the wrong source select, a wrong stack action or a wrong OR mask in the cycle that opcode executes. The bench loads a flag pattern with one instruction and tests it with the next. It also inserts non-loading instructions in between, so that a stray or missed capture shows as a flipped branch. A wrong pipeline-register value shows at the field outputs and the sequencer controls one cycle after the edge. In the count-ones routine, an error of either kind sends the program down the wrong path, which shows as a wrong final count or a wrong resting address.

// File: rtl/mpnc_pkg.sv
package mpnc_pkg;

    localparam int UW  = 32;   // microinstruction width
    localparam int OPW = 4;    // next-address control opcode width
    localparam int AW  = 4;    // microprogram address width
    localparam int NFL = 4;    // number of status flags

    localparam int FL_CARRY = 0;
    localparam int FL_ZERO  = 1;
    localparam int FL_MSB   = 2;
    localparam int FL_OVF   = 3;

    typedef enum logic [1:0] {
        SRC_UPC = 2'd0,
        SRC_REG = 2'd1,
        SRC_STK = 2'd2,
        SRC_DIR = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        SH_ZERO  = 2'd0,
        SH_ONE   = 2'd1,
        SH_ROT   = 2'd2,
        SH_ARITH = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        CC_CARRY = 2'd0,
        CC_ZERO  = 2'd1,
        CC_MSB   = 2'd2,
        CC_OVF   = 2'd3
    } cc_e;

    localparam logic [OPW-1:0] OP_CONT   = 4'd0;
    localparam logic [OPW-1:0] OP_JMP    = 4'd1;
    localparam logic [OPW-1:0] OP_CALL   = 4'd2;
    localparam logic [OPW-1:0] OP_RET    = 4'd3;
    localparam logic [OPW-1:0] OP_CALLZ  = 4'd12;
    localparam logic [OPW-1:0] OP_RETZ   = 4'd13;
    localparam logic [OPW-1:0] OP_LDST   = 4'd14;
    localparam logic [OPW-1:0] OP_TWOWAY = 4'd15;

    typedef struct packed {
        logic [OPW-1:0] nxt_op;
        logic [AW-1:0]  br_addr;
        logic           seq_cin;
        logic           br_ld;
        shift_e         shift;
        logic [2:0]     alu_src;
        logic [2:0]     alu_fn;
        logic [2:0]     alu_dst;
        logic [3:0]     a_addr;
        logic [3:0]     b_addr;
        logic           alu_cin;
        logic [1:0]     spare;
    } uword_t;

    localparam uword_t UWORD_NOP = '0;

    typedef struct packed {
        src_e          src;
        logic          fe;
        logic          push;
        logic [AW-1:0] orb;
    } seqctl_t;

    typedef struct packed {
        cc_e  sel;
        logic ld;
    } opattr_t;

    // Sequencer control entry for one opcode and one condition value.
    function automatic seqctl_t map_entry(input logic [OPW-1:0] op, input logic c);
        seqctl_t e;
        e.src  = SRC_UPC;
        e.fe   = 1'b0;
        e.push = 1'b0;
        e.orb  = '0;
        case (op)
            OP_JMP: e.src = SRC_DIR;
            OP_CALL: begin
                e.src  = SRC_DIR;
                e.fe   = 1'b1;
                e.push = 1'b1;
            end
            OP_RET: begin
                e.src = SRC_STK;
                e.fe  = 1'b1;
            end
            4'd4, 4'd5, 4'd6, 4'd7: if (c) e.src = SRC_DIR;
            4'd8, 4'd9, 4'd10, 4'd11: if (!c) e.src = SRC_DIR;
            OP_CALLZ: if (c) begin
                e.src  = SRC_DIR;
                e.fe   = 1'b1;
                e.push = 1'b1;
            end
            OP_RETZ: if (c) begin
                e.src = SRC_STK;
                e.fe  = 1'b1;
            end
            OP_TWOWAY: begin
                e.src = SRC_DIR;
                e.orb = {{(AW-1){1'b0}}, c};
            end
            default: e.src = SRC_UPC;
        endcase
        return e;
    endfunction

    // Per-opcode condition select and status-load enable.
    function automatic opattr_t op_attr(input logic [OPW-1:0] op);
        opattr_t a;
        a.ld = (op == OP_LDST);
        if (op >= 4'd4 && op <= 4'd11)
            a.sel = cc_e'(op[1:0]);
        else if (op == OP_CALLZ || op == OP_RETZ || op == OP_TWOWAY)
            a.sel = CC_ZERO;
        else
            a.sel = CC_CARRY;
        return a;
    endfunction

endpackage

// File: rtl/mpnc_pipe_reg.sv
module mpnc_pipe_reg
    import mpnc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [UW-1:0] word_in,
    output uword_t        word_q
);
    always_ff @(posedge clk) begin
        if (rst) word_q <= UWORD_NOP;
        else     word_q <= uword_t'(word_in);
    end
endmodule

// File: rtl/mpnc_status.sv
module mpnc_status
    import mpnc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ld,
    input  logic [NFL-1:0] flags_in,
    input  cc_e            sel,
    output logic [NFL-1:0] stat_q,
    output logic           cond
);
    always_ff @(posedge clk) begin
        if (rst)     stat_q <= '0;
        else if (ld) stat_q <= flags_in;
    end

    always_comb cond = stat_q[sel];
endmodule

// File: rtl/mpnc_map_rom.sv
module mpnc_map_rom
    import mpnc_pkg::*;
#(
    parameter int OP_BITS = OPW
) (
    input  logic [OP_BITS-1:0] op,
    input  logic               cond,
    output opattr_t            attr,
    output seqctl_t            ctl
);
    localparam int NOPS = 1 << OP_BITS;
    localparam int NSEQ = NOPS * 2;

    opattr_t attr_tab [NOPS];
    seqctl_t seq_tab  [NSEQ];

    for (genvar i = 0; i < NOPS; i++) begin : g_attr
        assign attr_tab[i] = op_attr(OPW'(i));
    end

    for (genvar j = 0; j < NSEQ; j++) begin : g_seq
        assign seq_tab[j] = map_entry(OPW'(j / 2), 1'(j % 2));
    end

    logic [OP_BITS:0] map_addr;
    always_comb begin
        map_addr = {op, cond};
        attr     = attr_tab[op];
        ctl      = seq_tab[map_addr];
    end
endmodule

// File: rtl/mpnc_shift_dec.sv
module mpnc_shift_dec
    import mpnc_pkg::*;
(
    input  shift_e code,
    input  logic   ram_lo_out,
    input  logic   ram_hi_out,
    input  logic   q_lo_out,
    input  logic   q_hi_out,
    output logic   ram_lo_in,
    output logic   ram_hi_in,
    output logic   q_lo_in,
    output logic   q_hi_in
);
    always_comb begin
        case (code)
            SH_ZERO: {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in} = 4'b0000;
            SH_ONE:  {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in} = 4'b1111;
            SH_ROT: begin
                ram_hi_in = ram_lo_out;
                ram_lo_in = ram_hi_out;
                q_hi_in   = q_lo_out;
                q_lo_in   = q_hi_out;
            end
            default: begin
                ram_hi_in = ram_hi_out;
                ram_lo_in = 1'b0;
                q_hi_in   = ram_lo_out;
                q_lo_in   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/mp_next_ctl.sv
module mp_next_ctl
    import mpnc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] fetch_word,
    input  logic [3:0]  alu_flags,
    input  logic        ram_lo_out,
    input  logic        ram_hi_out,
    input  logic        q_lo_out,
    input  logic        q_hi_out,
    output logic [1:0]  seq_src,
    output logic        seq_fe,
    output logic        seq_push,
    output logic [3:0]  seq_or,
    output logic [3:0]  seq_d,
    output logic        seq_cin,
    output logic        seq_rld,
    output logic [2:0]  alu_src,
    output logic [2:0]  alu_fn,
    output logic [2:0]  alu_dst,
    output logic [3:0]  a_addr,
    output logic [3:0]  b_addr,
    output logic        alu_cin,
    output logic        ram_lo_in,
    output logic        ram_hi_in,
    output logic        q_lo_in,
    output logic        q_hi_in
);
    uword_t         pr_word;
    logic [NFL-1:0] stat_q;
    logic           cond_bit;
    opattr_t        attr;
    seqctl_t        ctl;

    mpnc_pipe_reg u_pipe (
        .clk     (clk),
        .rst     (rst),
        .word_in (fetch_word),
        .word_q  (pr_word)
    );

    mpnc_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .ld       (attr.ld),
        .flags_in (alu_flags),
        .sel      (attr.sel),
        .stat_q   (stat_q),
        .cond     (cond_bit)
    );

    mpnc_map_rom #(.OP_BITS(OPW)) u_map (
        .op   (pr_word.nxt_op),
        .cond (cond_bit),
        .attr (attr),
        .ctl  (ctl)
    );

    mpnc_shift_dec u_shift (
        .code       (pr_word.shift),
        .ram_lo_out (ram_lo_out),
        .ram_hi_out (ram_hi_out),
        .q_lo_out   (q_lo_out),
        .q_hi_out   (q_hi_out),
        .ram_lo_in  (ram_lo_in),
        .ram_hi_in  (ram_hi_in),
        .q_lo_in    (q_lo_in),
        .q_hi_in    (q_hi_in)
    );

    always_comb begin
        seq_src  = ctl.src;
        seq_fe   = ctl.fe;
        seq_push = ctl.push;
        seq_or   = ctl.orb;
        seq_d    = pr_word.br_addr;
        seq_cin  = pr_word.seq_cin;
        seq_rld  = pr_word.br_ld;
        alu_src  = pr_word.alu_src;
        alu_fn   = pr_word.alu_fn;
        alu_dst  = pr_word.alu_dst;
        a_addr   = pr_word.a_addr;
        b_addr   = pr_word.b_addr;
        alu_cin  = pr_word.alu_cin;
    end
endmodule

// File: rtl/mp_next_ctl_chk.sv
module mp_next_ctl_chk
    import mpnc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_word,
    input uword_t      pr_word,
    input logic [3:0]  stat_q,
    input logic [1:0]  seq_src,
    input logic        seq_fe,
    input logic        seq_push,
    input logic [3:0]  seq_or,
    input logic        ram_lo_out,
    input logic        ram_hi_in
);
    // R1: pipeline register takes the fetched word every edge
    p_pipe_load_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (32'(pr_word) == $past(fetch_word)));

    // R7: status holds unless the load opcode executed
    p_stat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pr_word.nxt_op != OP_LDST) |=> $stable(stat_q));

    // R3: continue leaves the stack idle and picks the counter
    p_cont_src_r3: assert property (@(posedge clk) disable iff (rst)
        (pr_word.nxt_op == OP_CONT) |-> (seq_src == 2'd0 && !seq_fe));

    // R5: a pop always reads the stack top
    p_pop_stack_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_fe && !seq_push) |-> (seq_src == 2'd2));

    // R6: OR mask only for the two-way opcode
    p_or_twoway_r6: assert property (@(posedge clk) disable iff (rst)
        (seq_or != 4'd0) |-> (pr_word.nxt_op == OP_TWOWAY && seq_src == 2'd3));

    // R9: rotate feeds the low-end bit back to the high end
    p_rotate_r9: assert property (@(posedge clk) disable iff (rst)
        (pr_word.shift == SH_ROT) |-> (ram_hi_in == ram_lo_out));
endmodule

bind mp_next_ctl mp_next_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_word (fetch_word),
    .pr_word    (pr_word),
    .stat_q     (stat_q),
    .seq_src    (seq_src),
    .seq_fe     (seq_fe),
    .seq_push   (seq_push),
    .seq_or     (seq_or),
    .ram_lo_out (ram_lo_out),
    .ram_hi_in  (ram_hi_in)
);

// File: tb/sim_mp_next_ctl.sv
module sim_mp_next_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_word = '0;
    logic [3:0]  alu_flags = '0;
    logic        ram_lo_out = 1'b0, ram_hi_out = 1'b0, q_lo_out = 1'b0, q_hi_out = 1'b0;
    logic [1:0]  seq_src;
    logic        seq_fe, seq_push, seq_cin, seq_rld, alu_cin;
    logic [3:0]  seq_or, seq_d, a_addr, b_addr;
    logic [2:0]  alu_src, alu_fn, alu_dst;
    logic        ram_lo_in, ram_hi_in, q_lo_in, q_hi_in;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mp_next_ctl u0 (.*);

    function automatic logic [31:0] mkw(input logic [3:0] op, input logic [3:0] br,
                                        input logic [1:0] sh, input logic [2:0] fn);
        return {op, br, 1'b0, 1'b0, sh, 3'd0, fn, 3'd0, 4'd0, 4'd0, 1'b0, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one instruction: present word and flags, then wait past the edge
    task automatic cyc(input logic [31:0] w, input logic [3:0] f);
        @(negedge clk);
        fetch_word = w;
        alu_flags  = f;
        @(posedge clk);
        #1;
    endtask

    // {op, flags loaded before, src, fe, push, or}
    localparam logic [15:0] VEC [0:18] = '{
        {4'd0,  4'h0, 2'd0, 1'b0, 1'b0, 4'h0},
        {4'd1,  4'h0, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd2,  4'h0, 2'd3, 1'b1, 1'b1, 4'h0},
        {4'd3,  4'h0, 2'd2, 1'b1, 1'b0, 4'h0},
        {4'd4,  4'h1, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd4,  4'hE, 2'd0, 1'b0, 1'b0, 4'h0},
        {4'd5,  4'h2, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd6,  4'h4, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd7,  4'h8, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd7,  4'h7, 2'd0, 1'b0, 1'b0, 4'h0},
        {4'd8,  4'h0, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd9,  4'h2, 2'd0, 1'b0, 1'b0, 4'h0},
        {4'd12, 4'h2, 2'd3, 1'b1, 1'b1, 4'h0},
        {4'd12, 4'h0, 2'd0, 1'b0, 1'b0, 4'h0},
        {4'd13, 4'h2, 2'd2, 1'b1, 1'b0, 4'h0},
        {4'd13, 4'h0, 2'd0, 1'b0, 1'b0, 4'h0},
        {4'd15, 4'h2, 2'd3, 1'b0, 1'b0, 4'h1},
        {4'd15, 4'h0, 2'd3, 1'b0, 1'b0, 4'h0},
        {4'd14, 4'h5, 2'd0, 1'b0, 1'b0, 4'h0}
    };

    // count-ones routine state (bench models of sequencer, store and ALU)
    logic [31:0] store [16];
    logic [3:0]  upc;
    logic [3:0]  stk [4];
    int          sp;
    logic [7:0]  r0, r1;
    int          calls, rets;

    task automatic run_count(input logic [7:0] val);
        logic [3:0] addr, base;
        logic [3:0] f;
        r0 = val; r1 = 0; upc = 0; sp = 0; calls = 0; rets = 0;
        @(negedge clk); rst = 1'b1; fetch_word = '0; alu_flags = '0;
        @(posedge clk); #1;
        rst = 1'b0;
        for (int n = 0; n < 70; n++) begin
            f = 4'h0;
            if (alu_fn == 3'd1) begin
                f[0] = r0[0];
                f[1] = ((r0 >> 1) == 8'd0);
                r0 = r0 >> 1;
            end else if (alu_fn == 3'd2) begin
                r1 = r1 + 8'd1;
            end
            case (seq_src)
                2'd0: base = upc;
                2'd1: base = 4'd0;
                2'd2: base = (sp > 0) ? stk[sp-1] : 4'd0;
                default: base = seq_d;
            endcase
            addr = base | seq_or;
            if (seq_fe && seq_push && sp < 4) begin stk[sp] = upc; sp++; calls++; end
            else if (seq_fe && !seq_push && sp > 0) begin sp--; rets++; end
            upc = addr + 4'd1;
            cyc(store[addr], f);
        end
        chk($sformatf("R10 count of %0h", val), 32'(r1), 32'($countones(val)));
        chk("R10 rests in jump loop at 2", {28'd0, seq_d, seq_src == 2'd3}, {28'd0, 4'd2, 1'b1});
        chk("R10 one call and one return", calls * 16 + rets, 17);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) store[k] = mkw(4'd1, 4'd2, 2'd0, 3'd0);
        store[0] = mkw(4'd0,  4'd0, 2'd0, 3'd0);   // continue
        store[1] = mkw(4'd2,  4'd5, 2'd0, 3'd0);   // call 5
        store[2] = mkw(4'd1,  4'd2, 2'd0, 3'd0);   // jump 2 (halt)
        store[5] = mkw(4'd14, 4'd0, 2'd0, 3'd1);   // shift, load status
        store[6] = mkw(4'd8,  4'd8, 2'd0, 3'd0);   // jump 8 if no carry
        store[7] = mkw(4'd0,  4'd0, 2'd0, 3'd2);   // count++
        store[8] = mkw(4'd9,  4'd5, 2'd0, 3'd0);   // jump 5 if not zero
        store[9] = mkw(4'd3,  4'd0, 2'd0, 3'd0);   // return

        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset src", 32'(seq_src), 0);
        chk("R1 reset fields", {seq_fe, seq_push, seq_or, seq_d, alu_fn, a_addr}, 0);
        @(negedge clk); rst = 1'b0;

        // R7/R8: reset cleared status; live flags ignored by non-load op
        cyc(mkw(4'd8, 4'h3, 2'd0, 3'd0), 4'hF);
        chk("R7 status cleared by reset", 32'(seq_src), 3);
        chk("R8 live flags not used", 32'(seq_d), 3);

        // R2: field positions
        cyc({4'd0, 4'hA, 1'b1, 1'b1, 2'd0, 3'd5, 3'd3, 3'd6, 4'hC, 4'h3, 1'b1, 2'b11}, 4'h0);
        chk("R2 sequencer fields", {seq_d, seq_cin, seq_rld}, {4'hA, 1'b1, 1'b1});
        chk("R2 alu fields", {alu_src, alu_fn, alu_dst, a_addr, b_addr, alu_cin},
            {3'd5, 3'd3, 3'd6, 4'hC, 4'h3, 1'b1});

        // vector table: R3 R4 R5 R6
        foreach (VEC[v]) begin
            cyc(mkw(4'd14, 4'd0, 2'd0, 3'd0), VEC[v][11:8]);
            cyc(mkw(VEC[v][15:12], 4'd6, 2'd0, 3'd0), VEC[v][11:8]);
            chk($sformatf("R3/R4/R5/R6 vec %0d op %0d src", v, VEC[v][15:12]),
                32'(seq_src), 32'(VEC[v][7:6]));
            chk($sformatf("R5 vec %0d stack", v), {seq_fe, seq_push}, 32'(VEC[v][5:4]));
            chk($sformatf("R6 vec %0d or", v), 32'(seq_or), 32'(VEC[v][3:0]));
        end

        // R7: status loads only on opcode 14
        cyc(mkw(4'd14, 4'd0, 2'd0, 3'd0), 4'h2);
        cyc(mkw(4'd0,  4'd0, 2'd0, 3'd0), 4'h2);
        cyc(mkw(4'd0,  4'd0, 2'd0, 3'd0), 4'h0);
        cyc(mkw(4'd5,  4'd4, 2'd0, 3'd0), 4'h0);
        chk("R7 status held across non-load ops", 32'(seq_src), 3);

        // R9: shift decode
        cyc(mkw(4'd0, 4'd0, 2'd0, 3'd0), 4'h0);
        {ram_lo_out, ram_hi_out, q_lo_out, q_hi_out} = 4'b1111; #1;
        chk("R9 zero fill", {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in}, 0);
        cyc(mkw(4'd0, 4'd0, 2'd1, 3'd0), 4'h0);
        {ram_lo_out, ram_hi_out, q_lo_out, q_hi_out} = 4'b0000; #1;
        chk("R9 one fill", {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in}, 4'b1111);
        cyc(mkw(4'd0, 4'd0, 2'd2, 3'd0), 4'h0);
        {ram_lo_out, ram_hi_out, q_lo_out, q_hi_out} = 4'b1001; #1;
        chk("R9 rotate", {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in}, 4'b0110);
        cyc(mkw(4'd0, 4'd0, 2'd3, 3'd0), 4'h0);
        {ram_lo_out, ram_hi_out, q_lo_out, q_hi_out} = 4'b1111; #1;
        chk("R9 arithmetic", {ram_lo_in, ram_hi_in, q_lo_in, q_hi_in}, 4'b0101);
        {ram_lo_out, ram_hi_out, q_lo_out, q_hi_out} = 4'b0000;

        // R1: next word loads on the following edge
        cyc(mkw(4'd1, 4'd9, 2'd0, 3'd0), 4'h0);
        chk("R1 pipeline load", {seq_d, seq_src}, {4'd9, 2'd3});

        // R10: count-ones routine
        run_count(8'hB5);
        run_count(8'h00);
        run_count(8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule